// File: doc/BRIEF.md
# UART Modem Status and Control Unit

This unit holds the modem control byte and the modem status byte of a 16550-style serial port. Four modem input lines (clear-to-send, data-set-ready, ring indicator, carrier detect) are brought into the clock domain through a synchroniser. Their synchronised levels form the upper nibble of the status byte. Each change of a level sets a sticky change flag in the lower nibble. The ring flag is the exception: it is set only when the ring line drops.

Software reads the status byte through a read strobe. The read returns the current value, and the change flags clear on that same clock edge. A flag raised by a line change on that edge survives the clear. While any change flag is set and the modem-status interrupt enable is high, an interrupt request is raised.

The control byte drives the four modem outputs. It also holds a loopback switch. With loopback on, the status nibble is taken from the control bits instead of the pins, and the external request-to-send and terminal-ready outputs are held inactive.

Top module: `uart_modem_status`

## Requirements
- R1: After reset the status byte reads 0xB0 (carrier, data-set-ready and clear-to-send high, no flags), the control byte reads 0x08, and the interrupt request is low.
- R2: Outside loopback, status bits 4, 5, 6 and 7 follow modem_i bits 0 (CTS), 1 (DSR), 2 (RI) and 3 (DCD). A pin change is visible on msr_o after the third rising clock edge that follows it.
- R3: Bits 0, 1 and 3 of the status byte are set when status bit 4, 5 or 7, respectively, changes in either direction. They stay set until a read.
- R4: Bit 2 of the status byte is set only when status bit 6 goes from 1 to 0. A rise of bit 6 leaves it unchanged.
- R5: A cycle with msr_rd_i high presents the pre-clear value on msr_o. On the following edge bits 0 to 3 clear and bits 4 to 7 are kept.
- R6: A status change that takes effect on the same edge as a read still leaves its own change flag set after the read. Flags from earlier changes are cleared.
- R7: msi_irq_o is high exactly when msi_en_i is high and at least one of status bits 0 to 3 is set.
- R8: A control write stores only bits 0 to 4 of mcr_wdata_i. Bits 5 to 7 of mcr_o always read 0.
- R9: With control bit 4 set, status bit 4 shows control bit 1, bit 5 shows control bit 0, bit 6 shows control bit 2 and bit 7 shows control bit 3. The change flags follow the same rules as for pin changes.
- R10: With control bit 4 set, rts_o and dtr_o are low, and modem_i changes do not affect msr_o.
- R11: With control bit 4 clear, dtr_o, rts_o, out1_o and out2_o equal control bits 0, 1, 2 and 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| modem_i | input | 4 | Raw modem lines {DCD, RI, DSR, CTS}, active high |
| mcr_wr_i | input | 1 | Control byte write strobe |
| mcr_wdata_i | input | 8 | Control byte write data |
| msr_rd_i | input | 1 | Status byte read strobe (clears change flags) |
| msi_en_i | input | 1 | Modem-status interrupt enable |
| msr_o | output | 8 | Status byte read data |
| mcr_o | output | 8 | Control byte read data |
| dtr_o | output | 1 | Terminal-ready output |
| rts_o | output | 1 | Request-to-send output |
| out1_o | output | 1 | General output 1 |
| out2_o | output | 1 | General output 2 |
| msi_irq_o | output | 1 | Modem-status interrupt request |

## Verification
A stale status nibble is visible on msr_o as soon as the pins settle, at most three edges after a change. It then persists until the next change. A wrong flag update may stay hidden until a read. For that reason the bench reads after every step, and it also checks the cycle after each read so that a missed clear or a lost coincident flag shows within one edge. A lost or spurious flag also shows on msi_irq_o in the same cycle whenever the enable is high. Loopback faults show as soon as the control write lands.

// File: rtl/uart_modem_pkg.sv
package uart_modem_pkg;
  localparam int LINES = 4;
  localparam int BYTE_W = 8;
  // index of each line inside the status nibble
  localparam int L_CTS = 0;
  localparam int L_DSR = 1;
  localparam int L_RI  = 2;
  localparam int L_DCD = 3;
  // control byte bit positions
  localparam int C_DTR  = 0;
  localparam int C_RTS  = 1;
  localparam int C_OUT1 = 2;
  localparam int C_OUT2 = 3;
  localparam int C_LOOP = 4;

  // control bits presented as line levels when looped back
  function automatic logic [LINES-1:0] loop_lines(input logic [BYTE_W-1:0] ctl);
    logic [LINES-1:0] r;
    r[L_CTS] = ctl[C_RTS];
    r[L_DSR] = ctl[C_DTR];
    r[L_RI]  = ctl[C_OUT1];
    r[L_DCD] = ctl[C_OUT2];
    return r;
  endfunction
endpackage

// File: rtl/modem_sync.sv
module modem_sync #(
  parameter int WIDTH = 4,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  genvar g;
  generate
    for (g = 0; g < WIDTH; g++) begin : g_line
      logic [STAGES-1:0] chain_q;
      logic [STAGES-1:0] chain_d;
      always_comb begin
        chain_d = {chain_q[STAGES-2:0], async_i[g]};
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL[g]}};
        else        chain_q <= chain_d;
      end
      assign sync_o[g] = chain_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/modem_ctrl_reg.sv
module modem_ctrl_reg
  import uart_modem_pkg::*;
#(
  parameter int KEEP_W = 5,
  parameter logic [BYTE_W-1:0] RST_VAL = 8'h08
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] ctl_o,
  output logic              dtr_o,
  output logic              rts_o,
  output logic              out1_o,
  output logic              out2_o
);
  localparam logic [BYTE_W-1:0] KEEP_MASK = BYTE_W'((1 << KEEP_W) - 1);

  logic [BYTE_W-1:0] ctl_q, ctl_d;
  logic              loop;

  always_comb begin
    ctl_d = ctl_q;
    if (wr_i) ctl_d = wdata_i & KEEP_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= RST_VAL & KEEP_MASK;
    else        ctl_q <= ctl_d;
  end

  assign loop   = ctl_q[C_LOOP];
  assign ctl_o  = ctl_q;
  assign dtr_o  = ctl_q[C_DTR] & ~loop;
  assign rts_o  = ctl_q[C_RTS] & ~loop;
  assign out1_o = ctl_q[C_OUT1];
  assign out2_o = ctl_q[C_OUT2];
endmodule

// File: rtl/modem_status_reg.sv
module modem_status_reg
  import uart_modem_pkg::*;
#(
  parameter logic [LINES-1:0] RST_LINES = 4'b1011
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] lines_i,
  input  logic             rd_i,
  output logic [LINES-1:0] level_o,
  output logic [LINES-1:0] flag_o
);
  logic [LINES-1:0] level_q, level_d;
  logic [LINES-1:0] flag_q, flag_d;
  logic [LINES-1:0] diff, raise;

  always_comb begin
    diff  = level_q ^ lines_i;
    raise = diff;
    // ring flag only on a drop
    raise[L_RI] = level_q[L_RI] & ~lines_i[L_RI];
    level_d = lines_i;
    flag_d  = (rd_i ? '0 : flag_q) | raise;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= RST_LINES;
      flag_q  <= '0;
    end else begin
      level_q <= level_d;
      flag_q  <= flag_d;
    end
  end

  assign level_o = level_q;
  assign flag_o  = flag_q;
endmodule

// File: rtl/uart_modem_status.sv
module uart_modem_status
  import uart_modem_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter logic [3:0] STAT_RST = 4'b1011,
  parameter logic [7:0] CTL_RST = 8'h08
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] modem_i,
  input  logic       mcr_wr_i,
  input  logic [7:0] mcr_wdata_i,
  input  logic       msr_rd_i,
  input  logic       msi_en_i,
  output logic [7:0] msr_o,
  output logic [7:0] mcr_o,
  output logic       dtr_o,
  output logic       rts_o,
  output logic       out1_o,
  output logic       out2_o,
  output logic       msi_irq_o
);
  logic [LINES-1:0]  pins_sync;
  logic [LINES-1:0]  lines_sel;
  logic [LINES-1:0]  level, flag;
  logic [BYTE_W-1:0] ctl;

  modem_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES), .RST_VAL(STAT_RST)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(modem_i), .sync_o(pins_sync)
  );

  modem_ctrl_reg #(.KEEP_W(5), .RST_VAL(CTL_RST)) u_ctl (
    .clk(clk), .rst_n(rst_n), .wr_i(mcr_wr_i), .wdata_i(mcr_wdata_i),
    .ctl_o(ctl), .dtr_o(dtr_o), .rts_o(rts_o), .out1_o(out1_o), .out2_o(out2_o)
  );

  always_comb begin
    lines_sel = ctl[C_LOOP] ? loop_lines(ctl) : pins_sync;
  end

  modem_status_reg #(.RST_LINES(STAT_RST)) u_stat (
    .clk(clk), .rst_n(rst_n), .lines_i(lines_sel), .rd_i(msr_rd_i),
    .level_o(level), .flag_o(flag)
  );

  assign msr_o     = {level, flag};
  assign mcr_o     = ctl;
  assign msi_irq_o = msi_en_i & (|flag);
endmodule

// File: rtl/uart_modem_status_chk.sv
module uart_modem_status_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       msr_rd_i,
  input logic       msi_en_i,
  input logic [7:0] msr_o,
  input logic [7:0] mcr_o,
  input logic       dtr_o,
  input logic       rts_o,
  input logic       msi_irq_o
);
  // R3
  cts_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msr_o[4] != $past(msr_o[4])) |-> msr_o[0]);
  // R3
  dcd_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msr_o[7] != $past(msr_o[7])) |-> msr_o[3]);
  // R4
  ring_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(msr_o[6]) |-> msr_o[2]);
  // R4
  ring_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(msr_o[6]) && !$past(msr_o[2])) |-> !msr_o[2]);
  // R5
  read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(msr_rd_i) && $stable(msr_o[7:4])) |-> (msr_o[3:0] == 4'h0));
  // R7
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !msi_en_i |-> !msi_irq_o);
  // R8
  ctl_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mcr_o[7:5] == 3'b000);
  // R10
  loop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mcr_o[4] |-> (!dtr_o && !rts_o));
endmodule

bind uart_modem_status uart_modem_status_chk u_chk (
  .clk(clk), .rst_n(rst_n), .msr_rd_i(msr_rd_i), .msi_en_i(msi_en_i),
  .msr_o(msr_o), .mcr_o(mcr_o), .dtr_o(dtr_o), .rts_o(rts_o),
  .msi_irq_o(msi_irq_o)
);

// File: tb/uart_modem_status_bench.sv
module uart_modem_status_bench;
  logic       clk;
  logic       rst_n;
  logic [3:0] modem_i;
  logic       mcr_wr_i;
  logic [7:0] mcr_wdata_i;
  logic       msr_rd_i;
  logic       msi_en_i;
  logic [7:0] msr_o, mcr_o;
  logic       dtr_o, rts_o, out1_o, out2_o, msi_irq_o;

  int n_cmp, n_bad;
  logic done;
  logic [3:0] e_lvl, e_flg, pins;
  logic [7:0] e_ctl;

  uart_modem_status u_uart_modem_status (
    .clk(clk), .rst_n(rst_n), .modem_i(modem_i), .mcr_wr_i(mcr_wr_i),
    .mcr_wdata_i(mcr_wdata_i), .msr_rd_i(msr_rd_i), .msi_en_i(msi_en_i),
    .msr_o(msr_o), .mcr_o(mcr_o), .dtr_o(dtr_o), .rts_o(rts_o),
    .out1_o(out1_o), .out2_o(out2_o), .msi_irq_o(msi_irq_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [3:0] src_lines(input logic [7:0] c, input logic [3:0] p);
    if (c[4]) return {c[3], c[2], c[0], c[1]};
    return p;
  endfunction

  function automatic logic [3:0] flag_raise(input logic [3:0] o, input logic [3:0] n);
    logic [3:0] r;
    r = o ^ n;
    r[2] = o[2] & ~n[2];
    return r;
  endfunction

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%02h exp=%02h", req, got, exp);
    end
  endtask

  task automatic settle();
    logic [3:0] nl;
    nl = src_lines(e_ctl, pins);
    e_flg = e_flg | flag_raise(e_lvl, nl);
    e_lvl = nl;
  endtask

  task automatic check_all();
    chk("R2/R3/R4/R9 msr", msr_o, {e_lvl, e_flg});
    chk("R7 irq", {7'd0, msi_irq_o}, {7'd0, msi_en_i & (|e_flg)});
    chk("R8 mcr", mcr_o, e_ctl);
    chk("R10/R11 outs", {4'd0, out2_o, out1_o, rts_o, dtr_o},
        {4'd0, e_ctl[3], e_ctl[2], e_ctl[1] & ~e_ctl[4], e_ctl[0] & ~e_ctl[4]});
  endtask

  task automatic set_pins(input logic [3:0] v);
    pins = v;
    modem_i = v;
    repeat (4) @(negedge clk);
    settle();
    check_all();
  endtask

  task automatic wr_ctl(input logic [7:0] v);
    mcr_wdata_i = v;
    mcr_wr_i = 1'b1;
    @(negedge clk);
    mcr_wr_i = 1'b0;
    e_ctl = v & 8'h1F;
    repeat (2) @(negedge clk);
    settle();
    check_all();
  endtask

  task automatic rd_stat();
    chk("R5 read value", msr_o, {e_lvl, e_flg});
    msr_rd_i = 1'b1;
    @(negedge clk);
    msr_rd_i = 1'b0;
    e_flg = 4'h0;
    chk("R5 after read", msr_o, {e_lvl, 4'h0});
  endtask

  initial begin
    done = 1'b0;
    repeat (60000) @(negedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed;
    n_cmp = 0; n_bad = 0;
    seed = 32'd4242;
    void'($urandom(seed));
    rst_n = 1'b0; modem_i = 4'b1011; pins = 4'b1011;
    mcr_wr_i = 1'b0; mcr_wdata_i = 8'h00; msr_rd_i = 1'b0; msi_en_i = 1'b0;
    e_lvl = 4'b1011; e_flg = 4'h0; e_ctl = 8'h08;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 msr", msr_o, 8'hB0);
    chk("R1 mcr", mcr_o, 8'h08);
    chk("R1 irq", {7'd0, msi_irq_o}, 8'h00);

    // R2 latency: change visible only after the third edge
    msi_en_i = 1'b1;
    modem_i = 4'b1010; pins = 4'b1010;
    repeat (2) @(negedge clk);
    chk("R2 not yet", msr_o, 8'hB0);
    @(negedge clk);
    chk("R2 visible", msr_o, 8'hA1);
    chk("R7 irq on flag", {7'd0, msi_irq_o}, 8'h01);
    e_lvl = 4'b1010; e_flg = 4'b0001;
    rd_stat();

    // R4 ring rise does not flag, ring drop does
    set_pins(4'b1110);
    chk("R4 rise no flag", {4'd0, msr_o[3:0]}, 8'h00);
    set_pins(4'b1010);
    chk("R4 drop flags", {4'd0, msr_o[3:0]}, 8'h04);
    rd_stat();

    // R6 change on the same edge as a read
    set_pins(4'b1011);            // CTS flag pending
    modem_i = 4'b1001; pins = 4'b1001;   // DSR drops
    repeat (2) @(negedge clk);
    msr_rd_i = 1'b1;
    @(negedge clk);               // third edge: level update + clear
    msr_rd_i = 1'b0;
    chk("R6 coincident flag kept", msr_o, 8'h92);
    e_lvl = 4'b1001; e_flg = 4'b0010;
    rd_stat();

    // R8 masked control write, R11 outputs
    wr_ctl(8'hEF);
    wr_ctl(8'h0B);

    // R9 loopback mapping, R10 pins ignored
    wr_ctl(8'h15);                // loop, DTR, OUT1
    chk("R9 loop map", {msr_o[7:4], 4'h0}, 8'h60);
    set_pins(4'b0110);
    chk("R10 pins ignored", {msr_o[7:4], 4'h0}, 8'h60);
    rd_stat();
    wr_ctl(8'h1A);                // loop, RTS, OUT2
    chk("R9 loop map 2", {msr_o[7:4], 4'h0}, 8'h90);
    wr_ctl(8'h03);
    rd_stat();

    // random mix
    for (int i = 0; i < 300; i++) begin
      int op;
      op = int'($urandom_range(0, 3));
      case (op)
        0: set_pins(4'($urandom));
        1: rd_stat();
        2: wr_ctl(8'($urandom));
        default: begin
          msi_en_i = 1'($urandom);
          @(negedge clk);
          check_all();
        end
      endcase
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule